// File: doc/BRIEF.md
# Writeback Slot Allocator

This block shares a fixed number of writeback ports among the instructions that finish execution. It keeps a short time window of five cycles: the current cycle and the four after it. For every cycle in the window it counts how many completions are already booked to write back then. Several completion lanes can present a request in the same cycle. The lanes are handled in lane order, and each request is booked into the earliest cycle of the window that still has a free port. A request that must go into a later cycle than the current one adds to a penalty counter. A request that finds all five cycles full is dropped and raises an overflow flag.

Booked completions go into an in-order queue. In each cycle the queue releases up to the writeback width of its oldest entries. A released entry that is still live is marked commit-eligible and result-ready. It also raises a wakeup for its tag if it actually executed. A released entry that was squashed leaves the queue with no mark and no wakeup. An entry counts as squashed if it was squashed when it arrived, or if a kill naming its tag came while it was queued. The window moves forward one cycle per clock. The cycle that leaves the window has its count cleared, so it comes back as an empty far slot.

Top module: `wbSlotAlloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no entry is released, `penaltyCnt` reads zero and `bookOverflow` is low.
- R2: Requests in one cycle are handled from lane 0 upward. Each is booked at the smallest window offset (0 = current cycle) whose count is below `WB_WIDTH`, and that count is then raised by one.
- R3: The window spans offsets 0 to 4. A request that finds all five full is discarded: it is never released and it raises `bookOverflow` in the following cycle. `bookOverflow` stays low in every other cycle.
- R4: `penaltyCnt` grows by one for every booking at a nonzero offset, taking effect in the following cycle. It wraps modulo 2^`PEN_W`.
- R5: Each clock moves the window one cycle forward, so offset k becomes offset k-1. The slot leaving at offset 0 is cleared and comes back as an empty offset 4. After five cycles with no request, all slots are free.
- R6: A booked request can be released from the cycle after it arrives. In each cycle the `min(queued, WB_WIDTH)` oldest entries appear on pop lanes 0 upward, in arrival order (by lane order within one cycle), and are then removed.
- R7: A released entry that arrived with `cmplSquash` set, or whose tag matched `killTag` while `killValid` was high during an earlier cycle it spent queued (arrival cycle included), has `popValid` high and `markValid` and `wakeValid` low.
- R8: A released entry that is not squashed has `markValid` high, and `wakeValid` high exactly when it arrived with `cmplExec` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmplValid | input | NUM_LANES | Completion request per lane |
| cmplTag | input | NUM_LANES*TAG_W | Tag per lane, lane j in bits j*TAG_W upward |
| cmplExec | input | NUM_LANES | Instruction executed (wakeup wanted) |
| cmplSquash | input | NUM_LANES | Instruction already squashed |
| killValid | input | 1 | Squash queued entries that carry `killTag` |
| killTag | input | TAG_W | Tag to squash |
| popValid | output | WB_WIDTH | Entry released on this pop lane |
| popTag | output | WB_WIDTH*TAG_W | Tag of released entry per pop lane |
| markValid | output | WB_WIDTH | Commit-eligible and result-ready strobe |
| wakeValid | output | WB_WIDTH | Wakeup strobe for `popTag` |
| penaltyCnt | output | PEN_W | Count of deferred bookings |
| bookOverflow | output | 1 | A request found no free slot last cycle |

## Verification
A stale slot count, a wrong head rotation or a lane handled out of order does not change any release. It shows up one cycle after the booking, as a penalty step that is off by one or more, or as an overflow flag that comes too early or never comes. A queue pointer or occupancy fault shows up as soon as the affected entry reaches the head. It appears as a wrong tag, a missing or extra `popValid`, or a mark or wakeup that does not match the entry's squash and executed history. A burst of full-width requests checks the window depth, and an idle gap checks that the window drains.

// File: rtl/wbAllocPkg.sv
package wbAllocPkg;
  localparam int WIN_SLOTS = 5;
  localparam int MAX_LANES = 8;

  typedef struct packed {
    logic [MAX_LANES-1:0] push;
    logic                 anyPush;
  } allocStrb_t;
endpackage

// File: rtl/wbAllocCtrl.sv
module wbAllocCtrl
  import wbAllocPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WB_WIDTH  = 2,
  parameter int PEN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] cmplValid,
  output allocStrb_t           strb,
  output logic [PEN_W-1:0]     penaltyCnt,
  output logic                 bookOverflow
);
  localparam int CNT_W  = $clog2(WB_WIDTH + 1);
  localparam int HEAD_W = $clog2(WIN_SLOTS);

  logic [CNT_W-1:0]     slotCnt [WIN_SLOTS];
  logic [CNT_W-1:0]     workCnt [WIN_SLOTS];
  logic [HEAD_W-1:0]    headPtr;
  logic [NUM_LANES-1:0] pushMask;
  logic [NUM_LANES-1:0] lateMask;
  logic                 ovfAny;

  function automatic logic [HEAD_W-1:0] wrapSlot(input logic [HEAD_W-1:0] h, input int k);
    int s;
    s = int'(h) + k;
    if (s >= WIN_SLOTS) s = s - WIN_SLOTS;
    return HEAD_W'(s);
  endfunction

  // Lane-ordered search for the earliest slot with a free port.
  always_comb begin
    logic found;
    for (int k = 0; k < WIN_SLOTS; k++) workCnt[k] = slotCnt[wrapSlot(headPtr, k)];
    pushMask = '0;
    lateMask = '0;
    ovfAny   = 1'b0;
    for (int j = 0; j < NUM_LANES; j++) begin
      found = 1'b0;
      if (cmplValid[j]) begin
        for (int k = 0; k < WIN_SLOTS; k++) begin
          if (!found && (workCnt[k] < CNT_W'(WB_WIDTH))) begin
            workCnt[k]  = workCnt[k] + CNT_W'(1);
            found       = 1'b1;
            pushMask[j] = 1'b1;
            if (k != 0) lateMask[j] = 1'b1;
          end
        end
        if (!found) ovfAny = 1'b1;
      end
    end
  end

  always_comb begin
    strb = '0;
    strb.push[NUM_LANES-1:0] = pushMask;
    strb.anyPush = |pushMask;
  end

  // Window advance: the current slot retires and returns empty as the far slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < WIN_SLOTS; k++) slotCnt[k] <= '0;
      headPtr      <= '0;
      penaltyCnt   <= '0;
      bookOverflow <= 1'b0;
    end else begin
      for (int k = 0; k < WIN_SLOTS; k++)
        slotCnt[wrapSlot(headPtr, k)] <= (k == 0) ? '0 : workCnt[k];
      headPtr      <= wrapSlot(headPtr, 1);
      penaltyCnt   <= penaltyCnt + PEN_W'($countones(lateMask));
      bookOverflow <= ovfAny;
    end
  end
endmodule

// File: rtl/wbAllocData.sv
module wbAllocData
  import wbAllocPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WB_WIDTH  = 2,
  parameter int TAG_W     = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  allocStrb_t                strb,
  input  logic [NUM_LANES*TAG_W-1:0] cmplTag,
  input  logic [NUM_LANES-1:0]      cmplExec,
  input  logic [NUM_LANES-1:0]      cmplSquash,
  input  logic                      killValid,
  input  logic [TAG_W-1:0]          killTag,
  output logic [WB_WIDTH-1:0]       popValid,
  output logic [WB_WIDTH*TAG_W-1:0] popTag,
  output logic [WB_WIDTH-1:0]       markValid,
  output logic [WB_WIDTH-1:0]       wakeValid
);
  // Occupancy never exceeds the window capacity plus one cycle of bookings.
  localparam int QDEPTH = (WIN_SLOTS + 1) * WB_WIDTH;
  localparam int PTR_W  = $clog2(QDEPTH);
  localparam int OCC_W  = $clog2(QDEPTH + 1);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             done;
    logic             dead;
  } qEnt_t;

  qEnt_t             mem [QDEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [OCC_W-1:0]  occ;
  logic [PTR_W-1:0]  wrIdx [NUM_LANES];
  int                nPop, nPush;

  function automatic logic [PTR_W-1:0] wrapPtr(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= QDEPTH) s = s - QDEPTH;
    return PTR_W'(s);
  endfunction

  always_comb begin
    int acc;
    acc = 0;
    for (int j = 0; j < NUM_LANES; j++) begin
      wrIdx[j] = wrapPtr(wrPtr, acc);
      if (strb.push[j]) acc = acc + 1;
    end
    nPush = acc;
    nPop  = (int'(occ) < WB_WIDTH) ? int'(occ) : WB_WIDTH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < QDEPTH; e++) mem[e] <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
      occ   <= '0;
    end else begin
      for (int e = 0; e < QDEPTH; e++)
        if (killValid && (mem[e].tag == killTag)) mem[e].dead <= 1'b1;
      for (int j = 0; j < NUM_LANES; j++)
        if (strb.push[j])
          mem[wrIdx[j]] <= '{tag:  cmplTag[j*TAG_W +: TAG_W],
                              done: cmplExec[j],
                              dead: cmplSquash[j] |
                                    (killValid && (cmplTag[j*TAG_W +: TAG_W] == killTag))};
      rdPtr <= wrapPtr(rdPtr, nPop);
      wrPtr <= wrapPtr(wrPtr, nPush);
      occ   <= occ - OCC_W'(nPop) + OCC_W'(nPush);
    end
  end

  for (genvar i = 0; i < WB_WIDTH; i++) begin : g_pop
    logic [PTR_W-1:0] rdIdx;
    assign rdIdx        = wrapPtr(rdPtr, i);
    assign popValid[i]  = occ > OCC_W'(i);
    assign popTag[i*TAG_W +: TAG_W] = mem[rdIdx].tag;
    assign markValid[i] = popValid[i] & ~mem[rdIdx].dead;
    assign wakeValid[i] = markValid[i] & mem[rdIdx].done;
  end
endmodule

// File: rtl/wbSlotAlloc.sv
module wbSlotAlloc
  import wbAllocPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WB_WIDTH  = 2,
  parameter int TAG_W     = 6,
  parameter int PEN_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LANES-1:0]       cmplValid,
  input  logic [NUM_LANES*TAG_W-1:0] cmplTag,
  input  logic [NUM_LANES-1:0]       cmplExec,
  input  logic [NUM_LANES-1:0]       cmplSquash,
  input  logic                       killValid,
  input  logic [TAG_W-1:0]           killTag,
  output logic [WB_WIDTH-1:0]        popValid,
  output logic [WB_WIDTH*TAG_W-1:0]  popTag,
  output logic [WB_WIDTH-1:0]        markValid,
  output logic [WB_WIDTH-1:0]        wakeValid,
  output logic [PEN_W-1:0]           penaltyCnt,
  output logic                       bookOverflow
);
  allocStrb_t strb;

  wbAllocCtrl #(.NUM_LANES(NUM_LANES), .WB_WIDTH(WB_WIDTH), .PEN_W(PEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .strb(strb),
    .penaltyCnt(penaltyCnt), .bookOverflow(bookOverflow));

  wbAllocData #(.NUM_LANES(NUM_LANES), .WB_WIDTH(WB_WIDTH), .TAG_W(TAG_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmplTag(cmplTag), .cmplExec(cmplExec),
    .cmplSquash(cmplSquash), .killValid(killValid), .killTag(killTag),
    .popValid(popValid), .popTag(popTag), .markValid(markValid), .wakeValid(wakeValid));
endmodule

// File: rtl/wbSlotAllocChk.sv
module wbSlotAllocChk #(
  parameter int NUM_LANES = 4,
  parameter int WB_WIDTH  = 2,
  parameter int PEN_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LANES-1:0] cmplValid,
  input logic [WB_WIDTH-1:0]  popValid,
  input logic [WB_WIDTH-1:0]  markValid,
  input logic [WB_WIDTH-1:0]  wakeValid,
  input logic [PEN_W-1:0]     penaltyCnt,
  input logic                 bookOverflow
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (penaltyCnt == '0 && !bookOverflow && popValid == '0)); // R1
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN) bookOverflow |-> $past(|cmplValid)); // R3
  AST_PEN_CAUSE: assert property (@(posedge clk) disable iff (!rstN) (penaltyCnt != $past(penaltyCnt)) |-> $past(|cmplValid)); // R4
  AST_PEN_STEP: assert property (@(posedge clk) disable iff (!rstN) PEN_W'(penaltyCnt - $past(penaltyCnt)) <= PEN_W'(NUM_LANES)); // R4
  AST_MARK_POP: assert property (@(posedge clk) disable iff (!rstN) (markValid & ~popValid) == '0); // R8
  AST_WAKE_MARK: assert property (@(posedge clk) disable iff (!rstN) (wakeValid & ~markValid) == '0); // R7
  for (genvar i = 1; i < WB_WIDTH; i++) begin : g_ord
    AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rstN) popValid[i] |-> popValid[i-1]); // R6
  end
endmodule

bind wbSlotAlloc wbSlotAllocChk #(.NUM_LANES(NUM_LANES), .WB_WIDTH(WB_WIDTH), .PEN_W(PEN_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .popValid(popValid), .markValid(markValid),
  .wakeValid(wakeValid), .penaltyCnt(penaltyCnt), .bookOverflow(bookOverflow));

// File: tb/wbSlotAlloc_tb.sv
module wbSlotAlloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L   = 4;
  localparam int W   = 2;
  localparam int TW  = 6;
  localparam int PW  = 8;
  localparam int WIN = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [L-1:0] cmplValid = '0, cmplExec = '0, cmplSquash = '0;
  logic [L*TW-1:0] cmplTag = '0;
  logic killValid = 1'b0;
  logic [TW-1:0] killTag = '0;
  logic [W-1:0] popValid, markValid, wakeValid;
  logic [W*TW-1:0] popTag;
  logic [PW-1:0] penaltyCnt;
  logic bookOverflow;

  wbSlotAlloc #(.NUM_LANES(L), .WB_WIDTH(W), .TAG_W(TW), .PEN_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplExec(cmplExec),
    .cmplSquash(cmplSquash), .killValid(killValid), .killTag(killTag), .popValid(popValid),
    .popTag(popTag), .markValid(markValid), .wakeValid(wakeValid), .penaltyCnt(penaltyCnt),
    .bookOverflow(bookOverflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { logic [TW-1:0] tag; logic ex; logic sq; } ent_t;
  ent_t mq[$];
  int mcnt [WIN];
  logic [PW-1:0] mpen = '0;
  logic movf = 1'b0;
  logic [TW-1:0] nextTag = '0;
  int checks = 0, fails = 0;
  bit finished = 0, dutOvfSeen = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [L-1:0] v, input logic [L-1:0] ex, input logic [L-1:0] sq,
                      input logic kv, input logic [TW-1:0] kt);
    logic [TW-1:0] lt [L];
    int n;
    bit found;
    // compare present outputs with the model
    for (int i = 0; i < W; i++) begin
      bit ev = (i < mq.size());
      check(popValid[i] == ev, "R6", "popValid", popValid[i], ev);
      if (ev) begin
        bit em = !mq[i].sq;
        check(popTag[i*TW +: TW] == mq[i].tag, "R6", "popTag", popTag[i*TW +: TW], mq[i].tag);
        check(markValid[i] == em, mq[i].sq ? "R7" : "R8", "markValid", markValid[i], em);
        check(wakeValid[i] == (em && mq[i].ex), "R8", "wakeValid", wakeValid[i], em && mq[i].ex);
      end
    end
    check(penaltyCnt == mpen, "R4", "penaltyCnt", penaltyCnt, mpen);
    check(bookOverflow == movf, "R3", "bookOverflow", bookOverflow, movf);
    if (bookOverflow) dutOvfSeen = 1;
    // drive
    for (int j = 0; j < L; j++) begin
      lt[j] = nextTag;
      if (v[j]) nextTag = nextTag + 1'b1;
      cmplTag[j*TW +: TW] = lt[j];
    end
    cmplValid = v; cmplExec = ex; cmplSquash = sq; killValid = kv; killTag = kt;
    // model next state
    n = (mq.size() < W) ? mq.size() : W;
    for (int i = 0; i < n; i++) void'(mq.pop_front());
    if (kv) foreach (mq[q]) if (mq[q].tag == kt) mq[q].sq = 1'b1;
    movf = 1'b0;
    for (int j = 0; j < L; j++) begin
      if (v[j]) begin
        found = 0;
        for (int k = 0; k < WIN; k++) begin
          if (!found && mcnt[k] < W) begin
            mcnt[k]++;
            found = 1;
            if (k != 0) mpen = mpen + 1'b1;
          end
        end
        if (found) mq.push_back('{tag: lt[j], ex: ex[j], sq: sq[j] | (kv && lt[j] == kt)});
        else movf = 1'b1;
      end
    end
    for (int k = 0; k < WIN-1; k++) mcnt[k] = mcnt[k+1];
    mcnt[WIN-1] = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, '0, 1'b0, '0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish();
  end

  initial begin
    logic [PW-1:0] p0;
    for (int k = 0; k < WIN; k++) mcnt[k] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(popValid == '0, "R1", "popValid in reset", popValid, 0);
    check(penaltyCnt == '0, "R1", "penaltyCnt in reset", penaltyCnt, 0);
    check(bookOverflow == 1'b0, "R1", "bookOverflow in reset", bookOverflow, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(popValid == '0 && penaltyCnt == '0 && !bookOverflow, "R1", "first cycle quiet", popValid, 0);
    // Near-exhaustive sweep over lane masks and flag patterns
    for (int m = 0; m < 16; m++)
      for (int p = 0; p < 4; p++) begin
        step(L'(m), L'(m ^ p), L'((p == 3) ? (m & 5) : 0), 1'b0, '0);
        if (p == 1) idle(1);
      end
    idle(12);
    // R2: three requests at width 2 -> one deferral
    p0 = penaltyCnt;
    step(4'b0111, 4'b0111, '0, 1'b0, '0);
    check(penaltyCnt == p0 + 1'b1, "R2", "one deferral from three requests", penaltyCnt, p0 + 1'b1);
    idle(6);
    // R3: sustained full-width bursts must overflow the window
    for (int c = 0; c < 8; c++) step('1, 4'b1010, '0, 1'b0, '0);
    check(dutOvfSeen, "R3", "overflow observed under burst", dutOvfSeen, 1);
    idle(1);
    // R5: after five idle cycles all slots are free, two requests book at offset 0
    idle(5);
    p0 = penaltyCnt;
    step(4'b0011, 4'b0001, '0, 1'b0, '0);
    check(penaltyCnt == p0, "R5", "window drained after idle", penaltyCnt, p0);
    idle(20);
    // R7: kill a queued entry, and an arriving one in the same cycle
    step('1, '1, '0, 1'b0, '0);
    step(4'b0001, '1, '0, 1'b1, nextTag - 6'd1);
    step('0, '0, '0, 1'b1, nextTag - 6'd1);
    idle(6);
    // R4: long run to wrap the penalty counter
    for (int c = 0; c < 200; c++) begin
      step('1, L'(c), L'(c >> 2), c[3], nextTag - 6'd3);
      step(L'(c), '1, '0, 1'b0, '0);
      if (c % 3 == 0) idle(2);
    end
    idle(30);
    finish();
  end
endmodule